// File: doc/BRIEF.md
# Background Subtraction Binarizer

This block turns a stream of grayscale pixels into a one-bit foreground mask. Each clock cycle it may accept one pixel of the current frame together with the background pixel at the same position. It takes the magnitude of their difference and compares that with a threshold. The pixels arrive already reduced to luminance and already median-filtered. The background store sits upstream and is not part of this block.

The threshold adapts from frame to frame. While a frame streams through, the block sums the absolute differences and counts the pixels that contribute. When the last pixel of the frame has passed, a sequential divider turns that sum into an integer mean. The mean becomes the threshold for the next frame, taking effect from that frame's first pixel. Until the first frame's statistics exist, the block uses a threshold loaded from an input while reset is held.

Top module: `bgsub_binarize`

## Requirements
- R1: For every accepted pixel the mask bit is 1 exactly when |pixel − background| is strictly greater than the threshold in force for that pixel, and 0 otherwise.
- R2: A pixel equal to its background pixel always yields mask 0, whatever the threshold.
- R3: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and `out_mask` is 0 whenever `out_valid` is 0.
- R4: While `rst` is high the threshold register loads `init_thr`. After reset `out_valid` and `out_mask` are 0, `out_thr` equals that value, and that threshold applies until the first frame's mean is installed.
- R5: A frame runs from a valid pixel with `in_sof` = 1 through a valid pixel with `in_eof` = 1, both included. The threshold derived from it is floor(sum of the absolute differences / number of valid pixels), saturated to 8 bits.
- R6: A derived threshold comes into force at the next valid pixel flagged `in_sof`, provided at least 34 cycles separate the end-of-frame pixel from it. `out_thr` takes the new value in the same cycle as that pixel's mask appears.
- R7: Cycles with `in_valid` = 0 are ignored, including any `in_sof` or `in_eof` asserted on them. They neither add to the statistics nor start or end a frame.
- R8: A valid `in_sof` that arrives before the current frame's end restarts accumulation. The partial sum and count are discarded.
- R9: The difference never wraps. A background value above the pixel value gives the true magnitude; for example, pixel 0 against background 255 gives 255.
- R10: A single valid pixel flagged both `in_sof` and `in_eof` forms a complete frame whose derived threshold equals its own difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel pair is valid this cycle |
| in_pix | input | 8 | Current-frame grayscale pixel |
| in_bg | input | 8 | Background pixel at the same position |
| in_sof | input | 1 | First pixel of a frame (qualified by in_valid) |
| in_eof | input | 1 | Last pixel of a frame (qualified by in_valid) |
| init_thr | input | 8 | Threshold loaded while rst is high |
| out_valid | output | 1 | Mask output valid |
| out_mask | output | 1 | 1 = foreground, 0 = background |
| out_thr | output | 8 | Threshold currently in force |

## Verification
The assertions check several properties on every cycle: the two-cycle valid delay, the mask being zero when invalid, the mask being zero for an unchanged pixel, the mask never being set without a real difference, and the threshold changing only in a cycle that carries a valid result. Other behaviour can only be shown by the bench's scenarios, which compare against a frame-level model. This covers the exact mean arithmetic, the hand-over of the threshold at the next frame start, the restart on an early start-of-frame, the single-pixel frame, and invalid cycles that carry frame flags.

// File: rtl/bgsub_pkg.sv
package bgsub_pkg;

    parameter int PIX_W = 8;                 // grayscale sample width
    parameter int CNT_W = 20;                // pixel counter width per frame
    localparam int SUM_W = PIX_W + CNT_W;    // accumulator width, cannot overflow
    localparam int IT_W  = $clog2(SUM_W);    // divider step counter width

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // One beat leaving the difference stage
    typedef struct packed {
        logic valid;
        logic sof;
        logic eof;
        pix_t diff;
    } diff_beat_t;

    // Magnitude select: the smaller operand is always subtracted from the larger
    function automatic pix_t abs_diff(input pix_t a, input pix_t b);
        return (a >= b) ? pix_t'(a - b) : pix_t'(b - a);
    endfunction

    // Quotient narrowed to a sample, saturating
    function automatic pix_t sat_pix(input sum_t q);
        return (|q[SUM_W-1:PIX_W]) ? '1 : q[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/bgsub_absdiff.sv
module bgsub_absdiff
    import bgsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  pix_t       in_pix,
    input  pix_t       in_bg,
    input  logic       in_sof,
    input  logic       in_eof,
    output diff_beat_t beat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            beat.sof   <= in_valid & in_sof;
            beat.eof   <= in_valid & in_eof;
            beat.diff  <= abs_diff(in_pix, in_bg);
        end
    end

endmodule

// File: rtl/bgsub_stats.sv
module bgsub_stats
    import bgsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  diff_beat_t beat,
    output logic       start,
    output sum_t       tot,
    output cnt_t       num
);

    sum_t acc_sum, sum_nx;
    cnt_t acc_cnt, cnt_nx;

    always_comb begin
        if (beat.sof) begin
            sum_nx = sum_t'(beat.diff);
            cnt_nx = cnt_t'(1);
        end else begin
            sum_nx = acc_sum + sum_t'(beat.diff);
            cnt_nx = acc_cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_sum <= '0;
            acc_cnt <= '0;
            start   <= 1'b0;
            tot     <= '0;
            num     <= '0;
        end else begin
            start <= 1'b0;
            if (beat.valid) begin
                acc_sum <= sum_nx;
                acc_cnt <= cnt_nx;
                if (beat.eof) begin
                    start <= 1'b1;
                    tot   <= sum_nx;
                    num   <= cnt_nx;
                end
            end
        end
    end

endmodule

// File: rtl/bgsub_divider.sv
module bgsub_divider
    import bgsub_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  sum_t dividend,
    input  cnt_t divisor,
    output logic done,
    output sum_t quotient
);

    localparam logic [IT_W-1:0] IT_LAST = IT_W'(SUM_W - 1);

    logic              busy;
    logic [IT_W-1:0]   iter;
    cnt_t              rem;
    cnt_t              den;
    sum_t              qsh;
    logic [CNT_W:0]    trial;
    logic [CNT_W:0]    rem_nx;
    logic              ge;

    // One restoring step per cycle, most significant dividend bit first
    always_comb begin
        trial  = {rem, qsh[SUM_W-1]};
        ge     = trial >= {1'b0, den};
        rem_nx = ge ? (trial - {1'b0, den}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            iter <= '0;
            rem  <= '0;
            den  <= '0;
            qsh  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                iter <= '0;
                rem  <= '0;
                qsh  <= dividend;
                den  <= divisor;
            end else if (busy) begin
                rem <= rem_nx[CNT_W-1:0];
                qsh <= {qsh[SUM_W-2:0], ge};
                if (iter == IT_LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    iter <= iter + 1'b1;
                end
            end
        end
    end

    assign quotient = qsh;

endmodule

// File: rtl/bgsub_binarize.sv
module bgsub_binarize
    import bgsub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] in_bg,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] init_thr,
    output logic             out_valid,
    output logic             out_mask,
    output logic [PIX_W-1:0] out_thr
);

    diff_beat_t beat;
    logic       st_start;
    sum_t       st_tot;
    cnt_t       st_num;
    logic       dv_done;
    sum_t       dv_quo;

    pix_t       thr_cur;
    pix_t       thr_pend;
    logic       pend_ok;
    logic       apply;
    pix_t       thr_eff;

    bgsub_absdiff u_diff (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pix   (in_pix),
        .in_bg    (in_bg),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .beat     (beat)
    );

    bgsub_stats u_stats (
        .clk   (clk),
        .rst   (rst),
        .beat  (beat),
        .start (st_start),
        .tot   (st_tot),
        .num   (st_num)
    );

    bgsub_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (st_start),
        .dividend (st_tot),
        .divisor  (st_num),
        .done     (dv_done),
        .quotient (dv_quo)
    );

    // A waiting mean replaces the threshold at the first pixel of a frame
    always_comb begin
        apply   = beat.valid && beat.sof && pend_ok;
        thr_eff = apply ? thr_pend : thr_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_cur   <= init_thr;
            thr_pend  <= '0;
            pend_ok   <= 1'b0;
            out_valid <= 1'b0;
            out_mask  <= 1'b0;
        end else begin
            out_valid <= beat.valid;
            out_mask  <= beat.valid && (beat.diff > thr_eff);
            if (apply) begin
                thr_cur <= thr_pend;
                pend_ok <= 1'b0;
            end
            if (dv_done) begin
                thr_pend <= sat_pix(dv_quo);
                pend_ok  <= 1'b1;
            end
        end
    end

    assign out_thr = thr_cur;

endmodule

// File: rtl/bgsub_checker.sv
module bgsub_checker
    import bgsub_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_pix,
    input logic [PIX_W-1:0] in_bg,
    input logic             out_valid,
    input logic             out_mask,
    input logic [PIX_W-1:0] out_thr
);

    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign warm = (since_rst >= 2'd2);

    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2)));

    assert_mask_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_mask);

    assert_equal_is_background_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid && (in_pix == in_bg), 2)) |-> !out_mask);

    assert_mask_needs_difference_R1: assert property (@(posedge clk) disable iff (rst)
        (warm && out_mask) |-> $past(in_pix != in_bg, 2));

    assert_thr_moves_with_result_R6: assert property (@(posedge clk) disable iff (rst)
        (warm && !$stable(out_thr)) |-> out_valid);

endmodule

bind bgsub_binarize bgsub_checker u_chk (.*);

// File: tb/tb_bgsub_binarize.sv
module tb_bgsub_binarize;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_pix, in_bg;
    logic       in_sof, in_eof;
    logic [7:0] init_thr;
    logic       out_valid, out_mask;
    logic [7:0] out_thr;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int m_thr, m_pend, m_sum, m_cnt;
    bit m_pend_ok;
    bit hv [2];
    bit hm [2];
    int ht [2];
    string hr [2];

    always #10 clk = ~clk;   // 50 MHz

    bgsub_binarize dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .in_bg(in_bg),
        .in_sof(in_sof), .in_eof(in_eof), .init_thr(init_thr),
        .out_valid(out_valid), .out_mask(out_mask), .out_thr(out_thr)
    );

    function automatic int mag(input int a, input int b);
        return (a >= b) ? a - b : b - a;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // One cycle: compare outputs due now, then drive a new input pair
    task automatic step(input bit v, input int p, input int b, input bit s, input bit e,
                        input string req);
        int d;
        bit mk;
        @(negedge clk);
        checks++;
        if (out_valid !== hv[1] || out_mask !== hm[1] || int'(out_thr) != ht[1]) begin
            fails++;
            $display("FAIL %s: got valid=%0b mask=%0b thr=%0d, expected valid=%0b mask=%0b thr=%0d",
                     hr[1], out_valid, out_mask, out_thr, hv[1], hm[1], ht[1]);
        end
        in_valid = v; in_pix = 8'(p); in_bg = 8'(b); in_sof = s; in_eof = e;
        d  = mag(p, b);
        mk = 1'b0;
        if (v) begin
            if (s && m_pend_ok) begin   // R6 hand-over at frame start
                m_thr = m_pend;
                m_pend_ok = 1'b0;
            end
            mk = d > m_thr;
            if (s) begin m_sum = d; m_cnt = 1; end            // R8 restart
            else begin m_sum += d; m_cnt++; end
            if (e) begin m_pend = m_sum / m_cnt; m_pend_ok = 1'b1; end  // R5, R10
        end
        hv[1] = hv[0]; hm[1] = hm[0]; ht[1] = ht[0]; hr[1] = hr[0];
        hv[0] = v; hm[0] = mk; ht[0] = m_thr; hr[0] = req;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, $urandom_range(255), $urandom_range(255),
                 1'($urandom_range(1)), 1'($urandom_range(1)), "R7");
    endtask

    task automatic rand_frame(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int p, b;
            p = $urandom_range(255);
            b = ($urandom_range(3) == 0) ? p : $urandom_range(255);
            if ($urandom_range(5) == 0) idle(1);   // R7 gaps inside a frame
            step(1'b1, p, b, i == 0, i == n - 1, req);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_pix = '0; in_bg = '0;
        in_sof = 1'b0; in_eof = 1'b0; init_thr = 8'd40;
        m_thr = 40; m_pend = 0; m_pend_ok = 1'b0; m_sum = 0; m_cnt = 0;
        for (int i = 0; i < 2; i++) begin hv[i] = 1'b0; hm[i] = 1'b0; ht[i] = 40; hr[i] = "R3"; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_mask !== 1'b0 || out_thr !== 8'd40) begin
            fails++;
            $display("FAIL R4: got valid=%0b mask=%0b thr=%0d, expected 0 0 40",
                     out_valid, out_mask, out_thr);
        end

        // first frame under the loaded threshold
        rand_frame(60, "R1");
        idle(40);

        // directed: magnitudes, equal pairs, extremes
        step(1'b1,   0, 255, 1'b1, 1'b0, "R9");
        step(1'b1, 255,   0, 1'b0, 1'b0, "R9");
        step(1'b1, 200, 200, 1'b0, 1'b0, "R2");
        step(1'b1,   0,   0, 1'b0, 1'b0, "R2");
        step(1'b1,  10, 250, 1'b0, 1'b0, "R9");
        step(1'b1, 128, 127, 1'b0, 1'b1, "R5");
        idle(40);

        // threshold from the directed frame in force
        rand_frame(30, "R6");
        idle(40);

        // early frame start discards the partial frame
        step(1'b1, 255, 0, 1'b1, 1'b0, "R8");
        step(1'b1, 255, 0, 1'b0, 1'b0, "R8");
        step(1'b1, 250, 0, 1'b0, 1'b0, "R8");
        step(1'b1,  20, 0, 1'b1, 1'b0, "R8");
        step(1'b1,  30, 0, 1'b0, 1'b1, "R8");
        idle(40);

        // single-pixel frame
        step(1'b1, 90, 13, 1'b1, 1'b1, "R10");
        idle(40);
        step(1'b1, 90, 13, 1'b1, 1'b0, "R10");
        step(1'b1, 91, 13, 1'b0, 1'b0, "R10");
        step(1'b1, 89, 13, 1'b0, 1'b1, "R10");
        idle(40);

        for (int f = 0; f < 6; f++) begin
            rand_frame(20 + $urandom_range(60), "R5");
            idle(36 + $urandom_range(10));
        end
        idle(4);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

endmodule